// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a watchdog timer with a small register interface and a reset output. Software loads a tick count and sets the reset-configuration field in the control register to arm the timer. A prescaler turns the core clock into a tick, and the count drops by one on every tick. If the count reaches zero while the timer is armed, the block drives a reset pulse of fixed length to the system and records a watchdog cause bit in the status register. A write changes a register only when its top byte carries the unlock key, so a stray store cannot disarm or reload the timer.

The status register is cleared only by the block's own power-on reset. Software can therefore write a boot hint into it, for example a partition number spread over the even bits 0 to 10, where all ones means "halt", and read that hint back after the watchdog reset. Software keeps the system alive by rewriting the count before it runs out. Writing the control register with the configuration field at zero disarms the timer.

Top module: `wdog_rst_ctrl`

## Requirements
- R1: After power-on reset (`rst_ni` low), all three registers read as zero and `sys_rst_o` is low.
- R2: A write to any register takes effect only when `wdata_i[31:24]` equals 0x5A. A write with any other top byte leaves every register unchanged.
- R3: A keyed write to offset 0x24 loads `wdata_i[19:0]` into the count. Bits 23:20 are ignored. A read at 0x24 returns the remaining count in bits 19:0, with zeros above.
- R4: The count decrements by one on each tick. The first tick comes TICK_DIV clocks after reset is released, and later ticks follow every TICK_DIV clocks. The count stops at zero and never wraps.
- R5: A keyed write to offset 0x1C stores `wdata_i[5:4]` as the configuration field. A read at 0x1C returns that field in bits 5:4 and zero in every other bit. The timer is armed whenever bit 5 is 1.
- R6: The keyed value 0x5A000102 written to 0x1C clears the configuration field, and the timer then never raises `sys_rst_o`.
- R7: When the timer is armed, the count is zero and no pulse is in progress, `sys_rst_o` rises on the next clock edge and stays high for exactly RST_CYCLES (16) clocks.
- R8: On the edge where the pulse starts, the configuration field clears and status bit 5 is set. Both changes can be read while `sys_rst_o` is high.
- R9: Rewriting the count before it reaches zero reloads it, and no reset pulse occurs while the reloads continue.
- R10: A keyed write to offset 0x20 stores `wdata_i[10:0]` into the status register, which reads back in bits 10:0. A watchdog pulse does not clear the status register. For example, 0x555 written before expiry reads as 0x575 afterwards.
- R11: While the timer is not armed, the count runs down to zero and stays there, and `sys_rst_o` stays low.
- R12: A read at any other offset returns zero. A keyed write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data; bits 31:24 carry the key |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| sys_rst_o | output | 1 | Watchdog reset pulse to the system |

## Verification
Directed sequences come first. They try writes whose key byte is wrong, a short count that expires while armed, a status hint written before expiry, a chain of keepalive reloads, a disarm by the 0x102 pattern, and an unarmed run-down. Together these separate a rejected write from an accepted one, a reload from a decrement, and an armed expiry from an unarmed one. A random phase follows. It mixes keyed and unkeyed writes to all three registers and to an unmapped offset, with small counts so that expiries are frequent. It compares every read and the reset output against a cycle model, which shows whether priorities hold when writes, ticks and expiry fall in the same cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] UNLOCK_KEY = 8'h5A;
  localparam int OFS_CTRL = 'h1C;
  localparam int OFS_STAT = 'h20;
  localparam int OFS_CNT  = 'h24;
  localparam int CNT_W    = 20;
  localparam int STAT_W   = 11;
  localparam int CFG_LSB  = 4;
  localparam int STAT_WDOG_BIT = 5;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_CNT
  } reg_sel_e;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int DIV = 1907
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_passthru
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] count_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  // a load wins over a tick in the same cycle; the count holds at zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;
  assign zero_o  = (cnt_q == '0);
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int PW = $clog2(LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (trig_i)        left_q <= PW'(LEN);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/wdog_rst_ctrl.sv
module wdog_rst_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int TICK_DIV   = 1907,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sys_rst_o
);
  reg_sel_e           sel;
  logic               key_ok;
  logic               wr_ok;
  logic [1:0]         cfg_q;
  logic [STAT_W-1:0]  stat_q;
  logic [CNT_W-1:0]   cnt_val;
  logic               cnt_zero;
  logic               tick;
  logic               pulse_busy;
  logic               fire;
  logic               unused_wbits;

  assign unused_wbits = ^wdata_i[23:20];

  always_comb begin
    if      (addr_i == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (addr_i == ADDR_W'(OFS_CNT))  sel = SEL_CNT;
    else                                  sel = SEL_NONE;
  end

  assign key_ok = (wdata_i[31:24] == UNLOCK_KEY);
  assign wr_ok  = wr_en_i && key_ok;

  wdog_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  wdog_down_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_ok && sel == SEL_CNT),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .tick_i     (tick),
    .count_o    (cnt_val),
    .zero_o     (cnt_zero)
  );

  // expiry: armed, count exhausted, not already pulsing
  assign fire = cfg_q[1] && cnt_zero && !pulse_busy;

  wdog_pulse_gen #(.LEN(RST_CYCLES)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (fire),
    .busy_o (pulse_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cfg_q <= '0;
    else if (fire)                        cfg_q <= '0;
    else if (wr_ok && sel == SEL_CTRL)    cfg_q <= wdata_i[CFG_LSB+1:CFG_LSB];
  end

  // only power-on reset clears status; expiry ORs in the watchdog cause
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else begin
      if (wr_ok && sel == SEL_STAT) stat_q <= wdata_i[STAT_W-1:0];
      if (fire)                     stat_q[STAT_WDOG_BIT] <= 1'b1;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata_o = 32'(cfg_q) << CFG_LSB;
      SEL_STAT: rdata_o = 32'(stat_q);
      SEL_CNT:  rdata_o = 32'(cnt_val);
      default:  rdata_o = '0;
    endcase
  end

  assign sys_rst_o = pulse_busy;
endmodule

// File: rtl/wdog_rst_ctrl_chk.sv
module wdog_rst_ctrl_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int RST_CYCLES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              sys_rst_o,
  input logic [1:0]        cfg_q,
  input logic [STAT_W-1:0] stat_q,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              fire
);
  logic bad_key;
  logic cnt_load;
  int   hi_run;

  assign bad_key  = wr_en_i && (wdata_i[31:24] != UNLOCK_KEY);
  assign cnt_load = wr_en_i && (wdata_i[31:24] == UNLOCK_KEY) && (addr_i == ADDR_W'(OFS_CNT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_run <= 0;
    else if (sys_rst_o) hi_run <= hi_run + 1;
    else                hi_run <= 0;
  end

  p_key_ctrl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_key && !fire) |=> $stable(cfg_q));

  p_key_stat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_key && !fire) |=> $stable(stat_q));

  p_no_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_val == '0 && !cnt_load) |=> cnt_val == '0);

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_val != '0 && !cnt_load) |=> (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) - 1'b1));

  p_armed_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(cfg_q[1]));

  p_pulse_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> hi_run == RST_CYCLES);

  p_pulse_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> hi_run < RST_CYCLES);

  p_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> (cfg_q == 2'b00 && stat_q[STAT_WDOG_BIT]));
endmodule

bind wdog_rst_ctrl wdog_rst_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .RST_CYCLES (RST_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .sys_rst_o (sys_rst_o),
  .cfg_q     (cfg_q),
  .stat_q    (stat_q),
  .cnt_val   (cnt_val),
  .fire      (fire)
);

// File: tb/wdog_rst_ctrl_bench.sv
module wdog_rst_ctrl_bench;
  localparam int DIV  = 4;
  localparam int PLEN = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wdog_rst_ctrl #(.ADDR_W(8), .TICK_DIV(DIV), .RST_CYCLES(PLEN)) u_wdog_rst_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .sys_rst_o (sys_rst)
  );

  // cycle model built from the requirements
  int          m_div;
  logic [1:0]  m_cfg;
  logic [10:0] m_sts;
  logic [19:0] m_cnt;
  int          m_pls;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div <= 0; m_cfg <= '0; m_sts <= '0; m_cnt <= '0; m_pls <= 0;
    end else begin
      automatic bit acc  = wr_en && wdata[31:24] == 8'h5A;
      automatic bit tick = (m_div == DIV - 1);
      automatic bit fire = m_cfg[1] && m_cnt == 0 && m_pls == 0;
      automatic logic [10:0] s = m_sts;
      m_div <= tick ? 0 : m_div + 1;
      if (fire) m_cfg <= '0;
      else if (acc && addr == 8'h1C) m_cfg <= wdata[5:4];
      if (acc && addr == 8'h20) s = wdata[10:0];
      if (fire) s[5] = 1'b1;
      m_sts <= s;
      if (acc && addr == 8'h24) m_cnt <= wdata[19:0];
      else if (tick && m_cnt != 0) m_cnt <= m_cnt - 1'b1;
      m_pls <= fire ? PLEN : (m_pls != 0 ? m_pls - 1 : 0);
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h1C:   return {26'b0, m_cfg, 4'b0};
      8'h20:   return {21'b0, m_sts};
      8'h24:   return {12'b0, m_cnt};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h1C:   return "R5";
      8'h20:   return "R10";
      8'h24:   return "R4";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(tag_of(addr), rdata, exp_rd(addr));
    chk("R7", {31'b0, sys_rst}, {31'b0, (m_pls != 0)});
  endtask

  // drive one cycle, then compare at the following negedge
  task automatic cyc(bit we, logic [7:0] a, logic [31:0] d);
    wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    cmp_model();
  endtask

  task automatic idle(int n, logic [7:0] a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi;
    process::self().srandom(32'd20240611);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    addr = 8'h1C; #1 chk("R1", rdata, 32'h0);
    addr = 8'h20; #1 chk("R1", rdata, 32'h0);
    addr = 8'h24; #1 chk("R1", rdata, 32'h0);
    chk("R1", {31'b0, sys_rst}, 32'h0);

    // R2 wrong key ignored
    cyc(1'b1, 8'h1C, 32'h00000020); chk("R2", rdata, 32'h0);
    cyc(1'b1, 8'h20, 32'hA5000555); chk("R2", rdata, 32'h0);
    cyc(1'b1, 8'h24, 32'h5B000100); chk("R2", rdata, 32'h0);

    // R3 load masks bits 23:20
    cyc(1'b1, 8'h24, 32'h5AF12345); chk("R3", rdata & 32'hFFF00000, 32'h0);
    // R12 unmapped offset
    cyc(1'b1, 8'h30, 32'h5A0000FF); chk("R12", rdata, 32'h0);

    // R11 unarmed run-down to zero, no reset
    cyc(1'b1, 8'h24, 32'h5A000005);
    idle(40, 8'h24);
    chk("R11", rdata, 32'h0); chk("R11", {31'b0, sys_rst}, 32'h0);

    // R7/R8 armed expiry
    cyc(1'b1, 8'h20, 32'h5A000555);
    cyc(1'b1, 8'h24, 32'h5A000003);
    cyc(1'b1, 8'h1C, 32'h5A000020);
    chk("R5", rdata, 32'h20);
    hi = 0;
    for (int i = 0; i < 100 && !sys_rst; i++) cyc(1'b0, 8'h1C, 32'h0);
    chk("R8", rdata, 32'h0);
    while (sys_rst && hi < 40) begin hi++; cyc(1'b0, 8'h20, 32'h0); end
    chk("R7", hi, PLEN);
    chk("R10", rdata, 32'h575);

    // R9 keepalive
    cyc(1'b1, 8'h24, 32'h5A000008);
    cyc(1'b1, 8'h1C, 32'h5A000030);
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      cyc(1'b1, 8'h24, 32'h5A000008);
      for (int i = 0; i < 10; i++) begin cyc(1'b0, 8'h24, 32'h0); if (sys_rst) hi++; end
    end
    chk("R9", hi, 0);
    idle(60, 8'h1C);
    chk("R9", rdata, 32'h0);

    // R6 disarm pattern
    idle(20, 8'h1C);
    cyc(1'b1, 8'h24, 32'h5A000014);
    cyc(1'b1, 8'h1C, 32'h5A000020);
    cyc(1'b1, 8'h1C, 32'h5A000102);
    chk("R6", rdata, 32'h0);
    hi = 0;
    for (int i = 0; i < 200; i++) begin cyc(1'b0, 8'h24, 32'h0); if (sys_rst) hi++; end
    chk("R6", hi, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int r = $urandom_range(0, 3);
      a = (r == 0) ? 8'h1C : (r == 1) ? 8'h20 : (r == 2) ? 8'h24 : 8'h30;
      if ($urandom_range(0, 9) < 3) begin
        case (a)
          8'h24:   d = 32'($urandom_range(0, 60)) | ($urandom() & 32'h00F00000);
          8'h1C:   d = ($urandom_range(0, 4) == 0) ? 32'h102 : ($urandom() & 32'h3F);
          default: d = $urandom() & 32'h00FFFFFF;
        endcase
        d[31:24] = ($urandom_range(0, 4) == 0) ? 8'($urandom()) : 8'h5A;
        cyc(1'b1, a, d);
      end else begin
        cyc(1'b0, a, 32'h0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule